// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a countdown watchdog that sits on a small 16-bit register bus with byte enables. Software programs an initial count, clears a halt bit to start counting, and then reloads the counter from time to time. The counter moves down by one on each slow tick (one tick stands for 0.6 s). If it runs out, the block reloads it and raises a first-timeout flag.

If software does not clear that flag before the counter runs out again, the block raises a second-timeout flag. It then asks for a system reset with a one-cycle pulse, unless a no-reboot inhibit bit is set. A reset request also sets a sticky indicator and a boot flag. Only the block's own reset clears the sticky indicator.

Register map (byte addresses on even boundaries): 0x00 reload / live count, 0x04 status one, 0x06 status two, 0x08 control, 0x12 initial value. Unmapped addresses read as zero.

Top module: `wdt_top`

## Requirements
- R1: After reset: control reads 0x0801 (halt bit 11 = 1, no-reboot bit 0 = 1), initial value and count read 50, both status registers read 0, and reset_req and reset_seen are 0.
- R2: The initial value is the low 10 bits at 0x12. Byte enable bit 0 writes bits 7:0 and bit 1 writes bits 15:8. Bits 15:10 are not stored and read as 0.
- R3: A write to 0x12 whose resulting 10-bit value is below 4 is ignored, so the stored initial value is unchanged.
- R4: Any write to 0x00 loads the counter with the initial value, and this wins over a tick in the same cycle. A read of 0x00 returns the live count in bits 9:0.
- R5: While halt (control bit 11) is 1, ticks do not change the count.
- R6: While running, each tick lowers the count by one. A tick at count 0 is an expiry, and it reloads the initial value, so one period is initial+1 ticks.
- R7: An expiry while status-one bit 3 is clear sets that bit. Writing 1 to bit 3 at 0x04 clears it, and writing 0 leaves it set.
- R8: An expiry while status-one bit 3 is set sets status-two bit 1. If no-reboot is 0, it also sets status-two bit 2 and drives reset_req high for exactly one cycle, in the cycle after the tick.
- R9: Status-two bits 1 and 2 are each cleared by writing 1 to them at 0x06.
- R10: When no-reboot is 1, an escalation sets status-two bit 1 only, with no reset_req pulse and no boot flag. The bit reads back at control bit 0.
- R11: reset_seen goes high with the first reset_req pulse and stays high until rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick, one clock wide |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| reset_req | output | 1 | One-cycle reset request pulse |
| reset_seen | output | 1 | Sticky flag set by any reset request |

## Verification
A wrong count or a wrong initial value shows up at once on a read of 0x00 or 0x12. It also shifts an expiry by whole tick periods, so a status read taken one tick too early or too late exposes it. A first-timeout flag that is set or cleared wrongly only becomes visible one full period later, as a missing or extra second-timeout flag and reset pulse. The bench therefore reads both status registers after every expiry. It also counts the pulses and their widths on reset_req.

// File: rtl/wdt_pkg.sv
// Package: register offsets, field positions and reset values shared by the
// watchdog modules. Assumes a 16-bit data bus addressed in bytes.
package wdt_pkg;
    localparam int BUS_W    = 16;
    localparam int ADDR_W   = 5;
    localparam int BYTES    = BUS_W / 8;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT1  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT2  = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

    localparam int BIT_HALT     = 11;
    localparam int BIT_NOREBOOT = 0;
    localparam int BIT_FIRST    = 3;
    localparam int BIT_SECOND   = 1;
    localparam int BIT_BOOT     = 2;
endpackage

// File: rtl/wdt_regs.sv
// Register file: initial value, control bits, bus write decode into
// pulses, and the read multiplexer. Assumes CNT_W <= BUS_W.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 50,
    parameter int INIT_MIN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    input  logic [BYTES-1:0]    be,
    input  logic                we,
    input  logic [CNT_W-1:0]    count,
    input  logic                first_sts,
    input  logic                second_sts,
    input  logic                boot_sts,
    output logic [CNT_W-1:0]    init_val,
    output logic                halt,
    output logic                no_reboot,
    output logic                reload_p,
    output logic                clr_first_p,
    output logic                clr_second_p,
    output logic                clr_boot_p,
    output logic [BUS_W-1:0]    rdata
);
    localparam int PAD_W = BUS_W - CNT_W;

    logic [BUS_W-1:0] init_wide;
    logic [BUS_W-1:0] init_merged;
    logic [CNT_W-1:0] init_cand;
    logic             wr_init, wr_ctrl, wr_stat1, wr_stat2;

    assign init_wide = {{PAD_W{1'b0}}, init_val};

    // Per-byte merge of write data with the stored initial value.
    for (genvar b = 0; b < BYTES; b++) begin : g_merge
        assign init_merged[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : init_wide[b*8 +: 8];
    end
    assign init_cand = init_merged[CNT_W-1:0];

    // Address decode of the write strobe.
    always_comb begin
        wr_init  = we && (addr == OFS_INIT);
        wr_ctrl  = we && (addr == OFS_CTRL);
        wr_stat1 = we && (addr == OFS_STAT1);
        wr_stat2 = we && (addr == OFS_STAT2);
        reload_p = we && (addr == OFS_RELOAD);
        clr_first_p  = wr_stat1 && be[BIT_FIRST/8]  && wdata[BIT_FIRST];
        clr_second_p = wr_stat2 && be[BIT_SECOND/8] && wdata[BIT_SECOND];
        clr_boot_p   = wr_stat2 && be[BIT_BOOT/8]   && wdata[BIT_BOOT];
    end

    // Initial-value register; values below the minimum are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_val <= CNT_W'(INIT_RST);
        else if (wr_init && (init_cand >= CNT_W'(INIT_MIN)))
            init_val <= init_cand;
    end

    // Control bits, each written only under its own byte enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt      <= 1'b1;
            no_reboot <= 1'b1;
        end else if (wr_ctrl) begin
            if (be[BIT_HALT/8])     halt      <= wdata[BIT_HALT];
            if (be[BIT_NOREBOOT/8]) no_reboot <= wdata[BIT_NOREBOOT];
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_RELOAD: rdata = {{PAD_W{1'b0}}, count};
            OFS_INIT:   rdata = init_wide;
            OFS_STAT1:  rdata[BIT_FIRST] = first_sts;
            OFS_STAT2: begin
                rdata[BIT_SECOND] = second_sts;
                rdata[BIT_BOOT]   = boot_sts;
            end
            OFS_CTRL: begin
                rdata[BIT_HALT]     = halt;
                rdata[BIT_NOREBOOT] = no_reboot;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_counter.sv
// Countdown counter: reload on request, decrement on an enabled tick,
// and at zero signal an expiry and reload. Assumes ticks are one cycle wide.
module wdt_counter #(
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halt,
    input  logic             reload_p,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic tick_act;

    // A tick counts only when the timer is not halted.
    assign tick_act = tick_en && !halt;
    // Expiry happens on a counting tick at zero, unless a reload takes priority.
    assign expire   = tick_act && !reload_p && (count == '0);

    // Counter state: reload first, then expiry reload, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= CNT_W'(INIT_RST);
        else if (reload_p)
            count <= init_val;
        else if (tick_act)
            count <= (count == '0) ? init_val : count - 1'b1;
    end
endmodule

// File: rtl/wdt_escalate.sv
// Escalation: tracks the first and second timeout flags and the boot flag,
// issues the reset pulse and holds the sticky indicator. Assumes expire is
// a single-cycle pulse.
module wdt_escalate (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic no_reboot,
    input  logic clr_first_p,
    input  logic clr_second_p,
    input  logic clr_boot_p,
    output logic first_sts,
    output logic second_sts,
    output logic boot_sts,
    output logic reset_req,
    output logic reset_seen
);
    logic escalate, fire;

    // Second expiry is an expiry while the first flag is still set.
    assign escalate = expire && first_sts;
    assign fire     = escalate && !no_reboot;

    // Status flags: setting wins over a write-one-to-clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_sts  <= 1'b0;
            second_sts <= 1'b0;
            boot_sts   <= 1'b0;
        end else begin
            first_sts  <= (first_sts  && !clr_first_p)  || expire;
            second_sts <= (second_sts && !clr_second_p) || escalate;
            boot_sts   <= (boot_sts   && !clr_boot_p)   || fire;
        end
    end

    // Reset request pulse and its sticky record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req  <= 1'b0;
            reset_seen <= 1'b0;
        end else begin
            reset_req  <= fire;
            reset_seen <= reset_seen || fire;
        end
    end
endmodule

// File: rtl/wdt_top.sv
// Top of the two-stage watchdog: joins the register file, the counter
// and the escalation logic. Assumes a synchronous active-low reset.
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 50,
    parameter int INIT_MIN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [4:0]         bus_addr,
    input  logic [15:0]        bus_wdata,
    input  logic [1:0]         bus_be,
    input  logic               bus_we,
    output logic [15:0]        bus_rdata,
    output logic               reset_req,
    output logic               reset_seen
);
    logic [CNT_W-1:0] init_val, count;
    logic halt, no_reboot, reload_p, expire;
    logic clr_first_p, clr_second_p, clr_boot_p;
    logic first_sts, second_sts, boot_sts;

    wdt_regs #(.CNT_W(CNT_W), .INIT_RST(INIT_RST), .INIT_MIN(INIT_MIN)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .be(bus_be), .we(bus_we), .count(count), .first_sts(first_sts),
        .second_sts(second_sts), .boot_sts(boot_sts), .init_val(init_val),
        .halt(halt), .no_reboot(no_reboot), .reload_p(reload_p),
        .clr_first_p(clr_first_p), .clr_second_p(clr_second_p),
        .clr_boot_p(clr_boot_p), .rdata(bus_rdata)
    );

    wdt_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
        .reload_p(reload_p), .init_val(init_val), .count(count), .expire(expire)
    );

    wdt_escalate esc_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .no_reboot(no_reboot),
        .clr_first_p(clr_first_p), .clr_second_p(clr_second_p),
        .clr_boot_p(clr_boot_p), .first_sts(first_sts),
        .second_sts(second_sts), .boot_sts(boot_sts),
        .reset_req(reset_req), .reset_seen(reset_seen)
    );
endmodule

// File: rtl/wdt_chk.sv
// Checker bound into wdt_top: temporal properties over the block's
// internal state and its outputs.
module wdt_chk #(
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt,
    input logic             reload_p,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] init_val,
    input logic             boot_sts,
    input logic             second_sts,
    input logic             reset_req,
    input logic             reset_seen
);
    // R3
    init_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= CNT_W'(INIT_MIN));

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload_p) |=> $stable(count));

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R8
    req_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (second_sts && boot_sts));

    // R11
    seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |=> reset_seen);

    // R11
    seen_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> reset_seen);
endmodule

bind wdt_top wdt_chk #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN)) chk_i (
    .clk(clk), .rst_n(rst_n), .halt(halt), .reload_p(reload_p),
    .count(count), .init_val(init_val), .boot_sts(boot_sts),
    .second_sts(second_sts), .reset_req(reset_req), .reset_seen(reset_seen)
);

// File: tb/wdt_top_tb_top.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor
// compares bus_rdata; a pulse monitor records reset_req behaviour.
module wdt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        reset_req, reset_seen;

    always #2 clk = ~clk;

    wdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .reset_req(reset_req), .reset_seen(reset_seen)
    );

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_vld = 1'b0;
    int          mon_checks = 0, mon_errs = 0;
    int          drv_checks = 0, drv_errs = 0;
    int          pulses = 0, wide = 0;
    logic        prev_req = 1'b0;

    // Monitor: compares each queued read against the design's data.
    always @(negedge clk) begin
        if (rd_vld && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            mon_checks++;
            if (bus_rdata !== e) begin
                mon_errs++;
                $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
            end
        end
    end

    // Pulse monitor for reset_req.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reset_req && !prev_req) pulses++;
            if (reset_req && prev_req)  wide++;
            prev_req <= reset_req;
        end
    end

    task automatic rd_expect(input logic [4:0] a, input logic [15:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_vld = 1'b1;
        @(posedge clk); #1;
        rd_vld = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] b);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_be = b; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 tick_en = 1'b1;
            @(posedge clk); #1 tick_en = 1'b0;
        end
        @(posedge clk); #1;
    endtask

    task automatic check(input logic ok, input string t, input int act, input int e);
        drv_checks++;
        if (!ok) begin
            drv_errs++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, e);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 200000);
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", mon_checks + drv_checks + 1, mon_errs + drv_errs + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check(reset_req == 1'b0 && reset_seen == 1'b0, "R1 outputs", int'(reset_seen), 0);
        rd_expect(5'h08, 16'h0801, "R1 control");
        rd_expect(5'h12, 16'd50,   "R1 init");
        rd_expect(5'h00, 16'd50,   "R1 count");
        rd_expect(5'h04, 16'h0000, "R1 stat1");
        rd_expect(5'h06, 16'h0000, "R1 stat2");
        // R3 illegal initial value ignored
        wr(5'h12, 16'h0002, 2'b11);
        rd_expect(5'h12, 16'd50, "R3 illegal ignored");
        wr(5'h12, 16'h0004, 2'b11);
        rd_expect(5'h12, 16'd4, "R3 minimum accepted");
        // R2 byte enables and unstored upper bits
        wr(5'h12, 16'h0210, 2'b01);
        rd_expect(5'h12, 16'h0010, "R2 low byte only");
        wr(5'h12, 16'h0210, 2'b10);
        rd_expect(5'h12, 16'h0210, "R2 high byte only");
        wr(5'h12, 16'hFC05, 2'b11);
        rd_expect(5'h12, 16'h0005, "R2 upper bits read zero");
        // R4 reload
        wr(5'h00, 16'h0000, 2'b11);
        rd_expect(5'h00, 16'd5, "R4 reload to init");
        // R5 halted
        ticks(3);
        rd_expect(5'h00, 16'd5, "R5 halted count");
        // R10 no-reboot readback after clear, start timer
        wr(5'h08, 16'h0000, 2'b11);
        rd_expect(5'h08, 16'h0000, "R10 no-reboot cleared");
        // R6 decrement
        ticks(2);
        rd_expect(5'h00, 16'd3, "R6 decrement");
        ticks(3);
        rd_expect(5'h00, 16'd0, "R6 at zero");
        rd_expect(5'h04, 16'h0000, "R7 no expiry yet");
        ticks(1);
        rd_expect(5'h00, 16'd5, "R6 reload on expiry");
        rd_expect(5'h04, 16'h0008, "R7 first timeout");
        rd_expect(5'h06, 16'h0000, "R8 no second yet");
        // R7 write-one-to-clear
        wr(5'h04, 16'h0008, 2'b11);
        rd_expect(5'h04, 16'h0000, "R7 cleared");
        ticks(6);
        rd_expect(5'h04, 16'h0008, "R7 set again");
        wr(5'h04, 16'h0000, 2'b11);
        rd_expect(5'h04, 16'h0008, "R7 zero write keeps");
        check(pulses == 0, "R8 no pulse after first", pulses, 0);
        // R8 escalation with reboot allowed
        ticks(6);
        rd_expect(5'h06, 16'h0006, "R8 second and boot");
        check(pulses == 1, "R8 one pulse", pulses, 1);
        check(wide == 0, "R8 pulse width", wide, 0);
        check(reset_seen == 1'b1, "R11 sticky set", int'(reset_seen), 1);
        // R9 clears
        wr(5'h06, 16'h0002, 2'b11);
        rd_expect(5'h06, 16'h0004, "R9 clear second");
        wr(5'h06, 16'h0004, 2'b11);
        rd_expect(5'h06, 16'h0000, "R9 clear boot");
        // R10 inhibit
        wr(5'h08, 16'h0001, 2'b11);
        rd_expect(5'h08, 16'h0001, "R10 readback");
        ticks(6);
        rd_expect(5'h06, 16'h0002, "R10 second only");
        check(pulses == 1, "R10 no pulse", pulses, 1);
        check(reset_seen == 1'b1, "R11 sticky held", int'(reset_seen), 1);
        // R4 reload while counting
        ticks(3);
        rd_expect(5'h00, 16'd2, "R4 counted");
        wr(5'h00, 16'h00FF, 2'b01);
        rd_expect(5'h00, 16'd5, "R4 service reload");
        // R5 halt again under high byte only
        wr(5'h08, 16'h0800, 2'b10);
        rd_expect(5'h08, 16'h0801, "R5 halt set");
        ticks(4);
        rd_expect(5'h00, 16'd5, "R5 halt holds");
        // R11 cleared only by reset
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        check(reset_seen == 1'b0, "R11 reset clears", int'(reset_seen), 0);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", mon_checks + drv_checks, mon_errs + drv_errs);
        $finish;
    end
endmodule